// File: doc/BRIEF.md
# Ordered Cross-Domain Reset and Enable Sequencer

This block sits in the control clock domain of a transfer engine. It drives the reset and enable lines of two data clock domains: a source domain, where data enters, and a destination domain, where data leaves. The same sequence runs at power-up and at every transfer shutdown, so the data paths never need a separate flush mechanism.

When the external enable drops during a run, the block first lowers its internal enable and then waits for the data path to report that it is idle. Next it drives reset into both data domains. Each domain counts its own clock edges while it is held in reset and reports back once it has seen enough of them. The block then releases the destination domain and waits until that domain confirms it is out of reset. Only after that does it release the source domain. The internal enable can rise again only once the whole sequence has finished.

Pause is lighter than shutdown. It removes the data-domain enables and leaves every register in the data paths untouched, so the transfer carries on where it stopped when pause is cleared.

Top module: `xdom_reset_seq`

## Requirements
- R1: While running, a low `ext_en` makes `core_en` fall at the next control clock edge. Neither domain reset rises until `path_idle` has been sampled high after that.
- R2: Each domain reset, once raised, stays high for at least HOLD_CYCLES (default 4) consecutive edges of its own domain clock. The slowest domain is therefore covered too.
- R3: `rst_dst` is deasserted strictly before `rst_src`. The source is released only after the destination has acknowledged that it is out of reset.
- R4: While `rst_ctl` is high, and after it is released, both domain resets are high. The startup release follows the same order and minimum hold as a shutdown.
- R5: `core_en` stays low from the start of a shutdown until both domain resets have been released, even if `ext_en` rises again earlier. After that it rises when `ext_en` is high.
- R6: While running, a high `pause` drives `en_src` and `en_dst` low and raises no domain reset. Clearing `pause` raises both enables again.
- R7: A domain enable is never high while that domain's reset is high. During `rst_ctl`, `en_src`, `en_dst` and `core_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ctl | input | 1 | Control domain clock |
| rst_ctl | input | 1 | System reset, active high, asynchronous assert |
| ext_en | input | 1 | External transfer enable (control domain) |
| pause | input | 1 | Pause request (control domain) |
| path_idle | input | 1 | Data path has no pending transactions (control domain) |
| core_en | output | 1 | Internal enable used by all modules (control domain) |
| clk_src | input | 1 | Source data domain clock |
| rst_src | output | 1 | Source domain reset, active high |
| en_src | output | 1 | Source domain enable, active high |
| clk_dst | input | 1 | Destination data domain clock |
| rst_dst | output | 1 | Destination domain reset, active high |
| en_dst | output | 1 | Destination domain enable, active high |

## Verification
The embedded properties check on every cycle that reset never rises before an idle report, that a domain reset never falls before its own hold counter has saturated, that the source is released only after the destination acknowledges release, that the internal enable is never high while any domain still reports reset, and that enables and resets of a domain never overlap. Other properties can only be shown by the bench's scenarios. These are the end-to-end order of the two reset falls at the pins, the count of slow-domain edges seen in reset, and the fact that a pause leaves the resets alone. They also include the blocking of an early re-enable and the startup sequence after system reset.

// File: rtl/rmgr_pkg.sv
package rmgr_pkg;

   typedef enum logic [2:0] {
      ST_ASSERT  = 3'd0,
      ST_REL_DST = 3'd1,
      ST_REL_SRC = 3'd2,
      ST_OFF     = 3'd3,
      ST_RUN     = 3'd4,
      ST_DRAIN   = 3'd5
   } seq_state_t;

   localparam int DOM_DST = 0;
   localparam int DOM_SRC = 1;
   localparam int NUM_DOM = 2;

endpackage

// File: rtl/rmgr_sync.sv
module rmgr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rmgr_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or posedge arst) begin
      if (arst) chain <= {STAGES{RST_VAL}};
      else      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/rmgr_domain.sv
module rmgr_domain #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic arst,
   input  logic rst_req,
   input  logic run_req,
   output logic rst_out,
   output logic en_out,
   output logic held_ack
);

   localparam int CW = $clog2(HOLD_CYCLES + 1);
   localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);

   logic          req_s;
   logic          run_s;
   logic          rst_q;
   logic          en_q;
   logic          ack_q;
   logic [CW-1:0] cnt;

   rmgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_req_sync (
      .clk(clk), .arst(arst), .d(rst_req), .q(req_s)
   );

   rmgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_run_sync (
      .clk(clk), .arst(arst), .d(run_req), .q(run_s)
   );

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         rst_q <= 1'b1;
         en_q  <= 1'b0;
         ack_q <= 1'b0;
         cnt   <= '0;
      end else begin
         rst_q <= req_s;
         en_q  <= run_s & ~req_s;
         ack_q <= rst_q && (cnt == HOLD_MAX);
         if (!rst_q)
            cnt <= '0;
         else if (cnt != HOLD_MAX)
            cnt <= cnt + 1'b1;
      end
   end

   assign rst_out  = rst_q;
   assign en_out   = en_q;
   assign held_ack = ack_q;

   // R2: reset may only drop after the local hold count saturated
   assert_hold_R2: assert property (@(posedge clk) disable iff (arst)
      $fell(rst_q) |-> (cnt == HOLD_MAX));

   // R7: enable and reset of one domain never overlap
   assert_en_no_rst_R7: assert property (@(posedge clk) disable iff (arst)
      en_q |-> !rst_q);

endmodule

// File: rtl/rmgr_ctl.sv
module rmgr_ctl
   import rmgr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ext_en,
   input  logic pause,
   input  logic path_idle,
   input  logic ack_src,
   input  logic ack_dst,
   output logic rst_req_src,
   output logic rst_req_dst,
   output logic run_req,
   output logic core_en
);

   seq_state_t state, nx;

   always_comb begin
      nx = state;
      unique case (state)
         ST_ASSERT:  if (ack_src && ack_dst) nx = ST_REL_DST;
         ST_REL_DST: if (!ack_dst)           nx = ST_REL_SRC;
         ST_REL_SRC: if (!ack_src)           nx = ST_OFF;
         ST_OFF:     if (ext_en)             nx = ST_RUN;
         ST_RUN:     if (!ext_en)            nx = ST_DRAIN;
         ST_DRAIN:   if (path_idle)          nx = ST_ASSERT;
         default:                            nx = ST_ASSERT;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state       <= ST_ASSERT;
         rst_req_src <= 1'b1;
         rst_req_dst <= 1'b1;
         run_req     <= 1'b0;
         core_en     <= 1'b0;
      end else begin
         state       <= nx;
         rst_req_src <= (nx == ST_ASSERT) || (nx == ST_REL_DST);
         rst_req_dst <= (nx == ST_ASSERT);
         run_req     <= (nx == ST_RUN) && !pause;
         core_en     <= (nx == ST_RUN);
      end
   end

   // R1: reset only after an idle report
   assert_idle_before_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $rose(rst_req_dst) |-> $past(path_idle));

   // R1: external disable removes the internal enable at once
   assert_shutdown_drop_R1: assert property (@(posedge clk) disable iff (rst)
      (core_en && !ext_en) |=> !core_en);

   // R3: source released only once destination acknowledged release
   assert_release_order_R3: assert property (@(posedge clk) disable iff (rst)
      $fell(rst_req_src) |-> (!rst_req_dst && !ack_dst));

   // R5: internal enable only when no domain reports reset
   assert_enable_after_seq_R5: assert property (@(posedge clk) disable iff (rst)
      core_en |-> (!ack_src && !ack_dst && !rst_req_src && !rst_req_dst));

endmodule

// File: rtl/xdom_reset_seq.sv
module xdom_reset_seq
   import rmgr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk_ctl,
   input  logic rst_ctl,
   input  logic ext_en,
   input  logic pause,
   input  logic path_idle,
   output logic core_en,
   input  logic clk_src,
   output logic rst_src,
   output logic en_src,
   input  logic clk_dst,
   output logic rst_dst,
   output logic en_dst
);

   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("HOLD_CYCLES must be at least one");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least two");
      end
   endgenerate

   logic [NUM_DOM-1:0] dom_clk;
   logic [NUM_DOM-1:0] dom_req;
   logic [NUM_DOM-1:0] dom_rst;
   logic [NUM_DOM-1:0] dom_en;
   logic [NUM_DOM-1:0] dom_ack;
   logic [NUM_DOM-1:0] ack_s;
   logic               req_src, req_dst, run_req;

   assign dom_clk[DOM_DST] = clk_dst;
   assign dom_clk[DOM_SRC] = clk_src;
   assign dom_req[DOM_DST] = req_dst;
   assign dom_req[DOM_SRC] = req_src;

   rmgr_ctl u_ctl (
      .clk(clk_ctl), .rst(rst_ctl), .ext_en(ext_en), .pause(pause),
      .path_idle(path_idle), .ack_src(ack_s[DOM_SRC]), .ack_dst(ack_s[DOM_DST]),
      .rst_req_src(req_src), .rst_req_dst(req_dst), .run_req(run_req),
      .core_en(core_en)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      rmgr_domain #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_leaf (
         .clk(dom_clk[d]), .arst(rst_ctl), .rst_req(dom_req[d]),
         .run_req(run_req), .rst_out(dom_rst[d]), .en_out(dom_en[d]),
         .held_ack(dom_ack[d])
      );
      rmgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
         .clk(clk_ctl), .arst(rst_ctl), .d(dom_ack[d]), .q(ack_s[d])
      );
   end

   assign rst_src = dom_rst[DOM_SRC];
   assign en_src  = dom_en[DOM_SRC];
   assign rst_dst = dom_rst[DOM_DST];
   assign en_dst  = dom_en[DOM_DST];

endmodule

// File: tb/tb_xdom_reset_seq.sv
`timescale 1ns/1ps
module tb_xdom_reset_seq;

   localparam real CTL_PERIOD = 10.0;
   localparam real SRC_PERIOD = 6.0;
   localparam real DST_PERIOD = 26.0;

   logic clk_ctl = 0, clk_src = 0, clk_dst = 0;
   logic rst_ctl = 1, ext_en = 0, pause = 0, path_idle = 1;
   logic core_en, rst_src, en_src, rst_dst, en_dst;

   int total = 0, bad = 0;
   int run_src = 0, run_dst = 0, hold_src = 0, hold_dst = 0;
   int rise_src = 0, rise_dst = 0, viol_core = 0, viol_en = 0;
   realtime t_fall_src = 0, t_fall_dst = 0;

   always #(CTL_PERIOD/2) clk_ctl = ~clk_ctl;
   always #(SRC_PERIOD/2) clk_src = ~clk_src;
   always #(DST_PERIOD/2) clk_dst = ~clk_dst;

   xdom_reset_seq dut (
      .clk_ctl(clk_ctl), .rst_ctl(rst_ctl), .ext_en(ext_en), .pause(pause),
      .path_idle(path_idle), .core_en(core_en), .clk_src(clk_src),
      .rst_src(rst_src), .en_src(en_src), .clk_dst(clk_dst),
      .rst_dst(rst_dst), .en_dst(en_dst)
   );

   always @(negedge clk_dst) begin
      if (rst_dst) run_dst++;
      else if (run_dst > 0) begin hold_dst = run_dst; run_dst = 0; end
      if (en_dst && rst_dst) viol_en++;
   end
   always @(negedge clk_src) begin
      if (rst_src) run_src++;
      else if (run_src > 0) begin hold_src = run_src; run_src = 0; end
      if (en_src && rst_src) viol_en++;
   end
   always @(posedge rst_src) rise_src++;
   always @(posedge rst_dst) rise_dst++;
   always @(negedge rst_src) t_fall_src = $realtime;
   always @(negedge rst_dst) t_fall_dst = $realtime;
   always @(negedge clk_ctl) if (core_en && (rst_src || rst_dst)) viol_core++;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk_ctl);
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0: return rst_src;
         1: return rst_dst;
         default: return core_en;
      endcase
   endfunction

   task automatic wait_for(input int sel, input logic val, input int lim, output bit ok);
      ok = 0;
      for (int i = 0; i < lim; i++) begin
         @(negedge clk_ctl);
         if (pick(sel) == val) begin ok = 1; break; end
      end
   endtask

   task automatic t_reset_state;
      cyc(5);
      check(rst_src == 1 && rst_dst == 1, "R4 resets high in sys reset", {rst_src, rst_dst}, 3);
      check(en_src == 0 && en_dst == 0 && core_en == 0, "R7 enables low in sys reset",
            {en_src, en_dst, core_en}, 0);
   endtask

   task automatic t_startup;
      bit ok;
      rst_ctl = 0;
      wait_for(0, 1'b0, 500, ok);
      check(ok, "R4 startup sequence completes", ok, 1);
      cyc(12);
      check(hold_dst >= 4, "R2 dst hold at startup", hold_dst, 4);
      check(hold_src >= 4, "R2 src hold at startup", hold_src, 4);
      check(t_fall_dst < t_fall_src, "R3 dst released first at startup",
            int'(t_fall_dst), int'(t_fall_src));
      check(core_en == 0, "R5 no enable without ext_en", core_en, 0);
   endtask

   task automatic t_run;
      ext_en = 1;
      cyc(2);
      check(core_en == 1, "R5 core_en after ext_en", core_en, 1);
      cyc(15);
      check(en_src == 1 && en_dst == 1, "R6 domain enables while running", {en_src, en_dst}, 3);
   endtask

   task automatic t_pause;
      int rs = rise_src, rd = rise_dst;
      pause = 1;
      cyc(15);
      check(en_src == 0 && en_dst == 0, "R6 pause drops enables", {en_src, en_dst}, 0);
      check(rst_src == 0 && rst_dst == 0 && rise_src == rs && rise_dst == rd,
            "R6 pause raises no reset", rise_src + rise_dst, rs + rd);
      pause = 0;
      cyc(15);
      check(en_src == 1 && en_dst == 1, "R6 resume restores enables", {en_src, en_dst}, 3);
   endtask

   task automatic t_shutdown_busy;
      bit ok;
      int rs = rise_src, rd = rise_dst;
      path_idle = 0;
      ext_en = 0;
      cyc(1);
      check(core_en == 0, "R1 core_en falls on disable", core_en, 0);
      cyc(60);
      check(rise_src == rs && rise_dst == rd && !rst_src && !rst_dst,
            "R1 no reset while path busy", rise_src + rise_dst, rs + rd);
      path_idle = 1;
      wait_for(1, 1'b1, 100, ok);
      check(ok, "R1 reset after idle", ok, 1);
      wait_for(0, 1'b0, 500, ok);
      cyc(12);
      check(ok && rise_src == rs + 1 && rise_dst == rd + 1, "R2 one reset pulse per domain",
            rise_src + rise_dst, rs + rd + 2);
      check(hold_dst >= 4, "R2 dst hold at shutdown", hold_dst, 4);
      check(hold_src >= 4, "R2 src hold at shutdown", hold_src, 4);
      check(t_fall_dst < t_fall_src, "R3 dst released first at shutdown",
            int'(t_fall_dst), int'(t_fall_src));
   endtask

   task automatic t_early_reenable;
      bit ok;
      ext_en = 1;
      wait_for(2, 1'b1, 20, ok);
      check(ok, "R5 run before early re-enable", ok, 1);
      ext_en = 0;
      wait_for(1, 1'b1, 100, ok);
      ext_en = 1;
      cyc(2);
      check(core_en == 0, "R5 enable held low during sequence", core_en, 0);
      wait_for(2, 1'b1, 600, ok);
      check(ok, "R5 enable rises after sequence", ok, 1);
      check(rst_src == 0 && rst_dst == 0, "R5 resets released before enable",
            {rst_src, rst_dst}, 0);
      check(viol_core == 0, "R5 enable never overlaps reset", viol_core, 0);
      check(viol_en == 0, "R7 domain enable never overlaps reset", viol_en, 0);
   endtask

   initial begin
      t_reset_state();
      t_startup();
      t_run();
      t_pause();
      t_shutdown_busy();
      t_early_reenable();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk_ctl);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule